// File: doc/BRIEF.md
# Four-Channel Capture/Compare Timer with Edge-Selectable Clear

This block is a free-running up-counter shared by four channels. Each channel works either as a compare register or as a capture register. A compare channel is loaded through a small write port. It produces a converter start pulse whenever the running count reaches its value. A capture channel stores the count when its external pin rises.

A single control word sets the channel modes and each channel's interrupt source. It also sets which transitions of an external clear pin return the counter to zero. Each channel drives one interrupt pulse. Depending on its select bit, that pulse follows either the channel's compare coincidence or a rising edge on the channel's external pin. All external pins pass through two-flop synchronizers before edge detection.

Top module: `cc_timer`

## Requirements
- R1: While reset is asserted and right after it, the count, all four channel values, every interrupt output and every converter trigger output are zero.
- R2: The count rises by one on each clock while cnt_en is 1 and holds while it is 0. It wraps from 0xFFFF to 0x0000.
- R3: ctrl[9:8] picks which clear-pin transitions reset the counter: 01 rising, 00 falling, 11 both, 10 none. The count reads zero three clocks after the pin changes. Clear wins over the increment and works while cnt_en is 0.
- R4: Bit ctrl[4+m] sets channel m to compare mode (1) or capture mode (0). A write with wr_en=1 and wr_sel=m loads wr_data into channel m one clock later, but only if the channel is in compare mode. A write to a capture channel leaves its value unchanged.
- R5: When a compare channel's value equals the count while cnt_en is 1, conv_trig[m] pulses for one clock in the next cycle. This happens whatever the channel's interrupt select is.
- R6: With ctrl[m]=0, irq[m] pulses together with conv_trig[m]. With ctrl[m]=1, irq[m] pulses for one clock three clocks after a rising edge on cap_pin[m], in either mode and whatever cnt_en is. Falling edges raise no interrupt.
- R7: In capture mode, a rising edge on cap_pin[m] loads the count into channel m three clocks later. The stored value is the count shown in the cycle before it appears. The edge is ignored while cnt_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counter enable; also gates capture |
| clr_pin | input | 1 | External clear pin (asynchronous) |
| cap_pin | input | 4 | Per-channel external capture/interrupt pins (asynchronous) |
| ctrl | input | 10 | [9:8] clear edge, [7:4] channel modes, [3:0] interrupt selects |
| wr_en | input | 1 | Compare value write strobe |
| wr_sel | input | 2 | Channel addressed by the write |
| wr_data | input | 16 | Compare value to write |
| count | output | 16 | Current counter value |
| chan_val | output | 64 | Channel values, channel m in bits 16m+15:16m |
| irq | output | 4 | Per-channel interrupt pulses |
| conv_trig | output | 4 | Per-channel compare coincidence pulses for a converter |

## Verification
The properties assume that cnt_en, ctrl, wr_en, wr_sel and wr_data are synchronous to the clock. Only the clear pin and the channel pins may change at any time. The interrupt property also assumes that the channel's interrupt select stays fixed during the cycle after a detected pin edge. The stimulus changes every input half a period after the rising edge. It changes the control word only while no pin edge is in flight through a synchronizer. Compare values are chosen so that no coincidence comes up during clear or wrap runs unless it is expected.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int W  = 16,
  parameter int CH = 4,
  localparam int SW = $clog2(CH),
  localparam int CW = 2 * CH + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_en,
  input  logic            clr_pin,
  input  logic [CH-1:0]   cap_pin,
  input  logic [CW-1:0]   ctrl,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [W-1:0]    wr_data,
  output logic [W-1:0]    count,
  output logic [CH*W-1:0] chan_val,
  output logic [CH-1:0]   irq,
  output logic [CH-1:0]   conv_trig
);

  logic [1:0]    clr_sy;
  logic          clr_d;
  logic [CH-1:0] pin_s1, pin_s2, pin_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_sy <= '0;
      clr_d  <= 1'b0;
      pin_s1 <= '0;
      pin_s2 <= '0;
      pin_d  <= '0;
    end else begin
      clr_sy <= {clr_sy[0], clr_pin};
      clr_d  <= clr_sy[1];
      pin_s1 <= cap_pin;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
    end
  end

  wire [1:0]    edge_sel = ctrl[CW-1:CW-2];
  wire [CH-1:0] mode     = ctrl[2*CH-1:CH];
  wire [CH-1:0] isel     = ctrl[CH-1:0];

  wire clr_rise = clr_sy[1] & ~clr_d;
  wire clr_fall = ~clr_sy[1] & clr_d;
  wire clr_hit  = (edge_sel == 2'b01 && clr_rise) ||
                  (edge_sel == 2'b00 && clr_fall) ||
                  (edge_sel == 2'b11 && (clr_rise || clr_fall));

  wire [CH-1:0] pin_rise = pin_s2 & ~pin_d;

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clr_hit) count <= '0;
    else if (cnt_en)  count <= count + 1'b1;
  end

  for (genvar m = 0; m < CH; m++) begin : g_ch
    logic [W-1:0] val;
    wire match = cnt_en && mode[m] && (count == val);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val          <= '0;
        irq[m]       <= 1'b0;
        conv_trig[m] <= 1'b0;
      end else begin
        if (!mode[m] && cnt_en && pin_rise[m])
          val <= count;
        else if (mode[m] && wr_en && wr_sel == SW'(m))
          val <= wr_data;
        irq[m]       <= isel[m] ? pin_rise[m] : match;
        conv_trig[m] <= match;
      end
    end

    assign chan_val[m*W +: W] = val;
  end

endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int W  = 16,
  parameter int CH = 4,
  localparam int CW = 2 * CH + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cnt_en,
  input logic            wr_en,
  input logic [CW-1:0]   ctrl,
  input logic [W-1:0]    count,
  input logic [CH*W-1:0] chan_val,
  input logic [CH-1:0]   irq,
  input logic [CH-1:0]   conv_trig,
  input logic            clr_hit,
  input logic [CH-1:0]   pin_rise
);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> count == '0);

  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !clr_hit |=> count == $past(count) + 1'b1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !clr_hit |=> $stable(count));

  a_r7_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !wr_en |=> $stable(chan_val));

  a_r5_trig_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    |conv_trig |-> $past(cnt_en));

  for (genvar m = 0; m < CH; m++) begin : g_chk
    a_r6_pin_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[m] && pin_rise[m] |=> irq[m]);

    a_r5_trig_compare_only: assert property (@(posedge clk) disable iff (!rst_n)
      conv_trig[m] |-> $past(ctrl[CH+m]));
  end

endmodule

bind cc_timer cc_timer_chk #(.W(W), .CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .ctrl(ctrl),
  .count(count), .chan_val(chan_val), .irq(irq), .conv_trig(conv_trig),
  .clr_hit(clr_hit), .pin_rise(pin_rise)
);

// File: tb/cc_timer_test.sv
module cc_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        clr_pin = 1'b0;
  logic [3:0]  cap_pin = '0;
  logic [9:0]  ctrl = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [63:0] chan_val;
  logic [3:0]  irq, conv_trig;

  cc_timer uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_pin(clr_pin),
    .cap_pin(cap_pin), .ctrl(ctrl), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .count(count), .chan_val(chan_val), .irq(irq),
    .conv_trig(conv_trig)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          cyc;
    int          kind;
    int          ch;
    logic [15:0] val;
    string       req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int base_cyc = 0;
  logic [15:0] base_val = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(logic [15:0] act, logic [15:0] exp, string req, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  task automatic push(int c, int k, int ch, logic [15:0] v, string r);
    item_t it;
    it.cyc = c; it.kind = k; it.ch = ch; it.val = v; it.req = r;
    sb.push_back(it);
  endtask

  logic [3:0] e_irq, e_trig;
  string r_irq, r_trig;
  always @(negedge clk) if (!done) begin
    e_irq = '0; e_trig = '0; r_irq = "R6"; r_trig = "R5";
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        case (sb[i].kind)
          0: begin e_irq[sb[i].ch] = 1'b1; r_irq = sb[i].req; end
          1: begin e_trig[sb[i].ch] = 1'b1; r_trig = sb[i].req; end
          2: chk(count, sb[i].val, sb[i].req, "count");
          default: chk(chan_val[sb[i].ch*16 +: 16], sb[i].val, sb[i].req, "chan_val");
        endcase
        sb.delete(i);
      end
    end
    chk({12'd0, irq}, {12'd0, e_irq}, r_irq, "irq");
    chk({12'd0, conv_trig}, {12'd0, e_trig}, r_trig, "conv_trig");
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic logic [15:0] predict(int c);
    return 16'(int'(base_val) + (c - base_cyc));
  endfunction

  task automatic wr(int ch, logic [15:0] v, logic [15:0] expv, string r);
    push(cyc + 1, 3, ch, expv, r);
    wr_en = 1'b1; wr_sel = 2'(ch); wr_data = v;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic clr_to(logic lvl, bit hit, string r);
    int t;
    t = cyc;
    if (hit) begin
      push(t + 3, 2, 0, 16'd0, r);
      push(t + 5, 2, 0, 16'd2, r);
      base_cyc = t + 3; base_val = '0;
    end else begin
      push(t + 3, 2, 0, predict(t + 3), r);
    end
    clr_pin = lvl;
    tick(6);
  endtask

  task automatic enable_now();
    base_cyc = cyc; base_val = count;
    cnt_en = 1'b1;
  endtask

  initial begin
    int t;
    logic [15:0] frozen, cap2;
    tick(3);
    rst_n = 1'b1;
    push(cyc + 1, 2, 0, 16'd0, "R1");
    for (int m = 0; m < 4; m++) push(cyc + 1, 3, m, 16'd0, "R1");
    tick(2);

    // compare setup: all compare, ch1 interrupt from pin, rising clear
    ctrl = 10'b01_1111_0010;
    wr(0, 16'h0040, 16'h0040, "R4");
    wr(1, 16'h0040, 16'h0040, "R4");
    wr(2, 16'h7000, 16'h7000, "R4");
    wr(3, 16'h7001, 16'h7001, "R4");

    t = cyc;
    enable_now();
    push(t + 5, 2, 0, 16'd5, "R2");
    push(t + 65, 0, 0, 0, "R6");
    push(t + 65, 1, 0, 0, "R5");
    push(t + 65, 1, 1, 0, "R5");
    tick(70);

    // hold while disabled
    t = cyc; frozen = predict(t);
    cnt_en = 1'b0;
    push(t + 3, 2, 0, frozen, "R2");
    tick(4);
    enable_now();
    tick(1);
    wr(0, 16'h8000, 16'h8000, "R4");
    wr(1, 16'h8000, 16'h8000, "R4");

    // write to a capture-mode channel is ignored
    ctrl = 10'b01_0111_0010;
    wr(3, 16'h1234, 16'h7001, "R4");
    tick(2);

    // clear edge selection
    clr_to(1'b1, 1'b1, "R3");
    clr_to(1'b0, 1'b0, "R3");
    ctrl[9:8] = 2'b00;
    clr_to(1'b1, 1'b0, "R3");
    clr_to(1'b0, 1'b1, "R3");
    ctrl[9:8] = 2'b11;
    clr_to(1'b1, 1'b1, "R3");
    clr_to(1'b0, 1'b1, "R3");
    ctrl[9:8] = 2'b10;
    clr_to(1'b1, 1'b0, "R3");
    clr_to(1'b0, 1'b0, "R3");

    // clear acts while disabled
    ctrl[9:8] = 2'b11;
    t = cyc;
    cnt_en = 1'b0;
    clr_pin = 1'b1;
    push(t + 3, 2, 0, 16'd0, "R3");
    push(t + 5, 2, 0, 16'd0, "R3");
    tick(6);
    ctrl[9:8] = 2'b10;
    clr_pin = 1'b0;
    tick(4);
    enable_now();
    tick(3);

    // capture and pin interrupts
    ctrl = 10'b10_0011_0110;
    t = cyc; cap2 = predict(t + 2);
    cap_pin[2] = 1'b1;
    push(t + 3, 3, 2, cap2, "R7");
    push(t + 3, 0, 2, 0, "R6");
    tick(6);
    t = cyc;
    cap_pin[2] = 1'b0;
    push(t + 4, 3, 2, cap2, "R7");
    tick(6);

    t = cyc;
    cap_pin[3] = 1'b1;
    push(t + 3, 3, 3, predict(t + 2), "R7");
    tick(6);
    cap_pin[3] = 1'b0;
    tick(5);

    t = cyc;
    cap_pin[1] = 1'b1;
    push(t + 3, 0, 1, 0, "R6");
    push(t + 4, 3, 1, 16'h8000, "R6");
    tick(6);
    cap_pin[1] = 1'b0;
    tick(5);

    t = cyc;
    cap_pin[0] = 1'b1;
    push(t + 4, 3, 0, 16'h8000, "R6");
    tick(6);
    cap_pin[0] = 1'b0;
    tick(5);

    // capture gated by enable; pin interrupt still raised
    t = cyc;
    cnt_en = 1'b0;
    cap_pin[2] = 1'b1;
    push(t + 3, 0, 2, 0, "R6");
    push(t + 4, 3, 2, cap2, "R7");
    tick(6);
    cap_pin[2] = 1'b0;
    tick(5);
    enable_now();
    tick(2);

    // wrap at 0xFFFF with compare on channel 3
    ctrl = 10'b10_1000_0000;
    wr(3, 16'hFFFF, 16'hFFFF, "R4");
    t = cyc + (16'hFFFF - int'(predict(cyc)));
    push(t + 1, 0, 3, 0, "R6");
    push(t + 1, 1, 3, 0, "R5");
    push(t + 1, 2, 0, 16'd0, "R2");
    push(t + 2, 2, 0, 16'd1, "R2");
    tick(t + 4 - cyc);

    tick(2);
    done = 1'b1;
    foreach (sb[i]) begin
      n_bad++;
      $display("FAIL %s never checked at cycle %0d: actual none expected %h", sb[i].req, sb[i].cyc, sb[i].val);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule